// File: doc/BRIEF.md
# Serial Two-Wire Byte Store with Timed Commit

This block is a synchronous two-wire (I2C) slave controller in front of a 256-byte register-held store. It oversamples the clock and data lines, detects start and stop conditions, and answers a 7-bit device address. The upper four bits of that address are a fixed type code, and the lower three come from strap inputs. Once addressed, it runs byte writes, page writes of up to eight bytes, and current-address, random and sequential reads. It drives the data line only through an open-drain pull-down enable.

Written bytes collect in a page buffer and reach the store only when the transaction closes with a stop. A repeated start or an aborted transfer drops them. A committed write opens a fixed-length busy window, counted in system clocks. During that window every bus event is ignored, so the device refuses its own address. A master can therefore poll with its address until it gets an acknowledge.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: The first byte after a start is the device byte, sent MSB first as type code 1010 in bits 7..4, strap copy in bits 3..1 and direction in bit 0 (0 write, 1 read). The block pulls SDA low during the ninth clock only when bits 7..4 equal 1010 and bits 3..1 equal `strap_i`.
- R2: After a non-matching device byte, the block releases SDA and acknowledges nothing until the next start.
- R3: In a write, the byte after the device byte sets the word pointer and is acknowledged. Every following data byte is acknowledged and goes to the pointed location, and the pointer then advances.
- R4: Within one write transaction the pointer advances only in its low 3 bits. Bytes past the end of an 8-byte page wrap to the start of the same page, and a later byte overwrites an earlier one in the same slot.
- R5: Buffered write data reaches the store only when a stop ends the transaction. After a repeated start the buffered data is discarded, no busy window opens and the store is unchanged.
- R6: A committed write starts a busy window of `WRITE_CYCLES` clocks. Inside it, a start followed by the matching device byte gets no acknowledge. After it ends, the same device byte is acknowledged.
- R7: A random read (a write of the word pointer, then a repeated start and a read device byte) returns the byte stored at that pointer.
- R8: In a read, the pointer advances after each byte sent and wraps from 255 to 0. A master acknowledge continues with the next byte. A master non-acknowledge releases SDA. A read with no word pointer continues from the current pointer.
- R9: After an interrupted read, nine SCL clocks with the master leaving SDA high, then a start, bring the block back to device-byte reception.
- R10: After reset, SDA is released, every store location reads 0 and the pointer is 0.
- R11: The SDA pull-down enable changes only in the clock after a sampled SCL falling edge, a start or a stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| strap_i | input | 3 | Device address strap bits |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench builds the block with a 500-clock write window and strap value 101, and keeps the default 256-byte store and 8-byte page. The short window makes an acknowledge-polling sequence take only a few polls, so both the refused and the accepted polls are reached. The small store lets one sequential read cover every location and the pointer wrap. All eight strap values and all sixteen type codes are swept for the device byte.

// File: rtl/eeprom_i2c_pkg.sv
// Shared types for the two-wire byte store controller.
package eeprom_i2c_pkg;
    // Bus engine states
    typedef enum logic [2:0] {
        ST_IDLE,    // ignoring the bus until a start
        ST_RX,      // shifting in a byte from the master
        ST_ACK,     // driving the acknowledge bit
        ST_TX,      // shifting out a read byte
        ST_RACK     // sampling the master acknowledge
    } bus_state_t;

    // Which byte of a write-direction transfer is being received
    typedef enum logic [1:0] {
        PH_DEV,     // device byte
        PH_ADDR,    // word pointer byte
        PH_DATA     // data bytes
    } rx_phase_t;
endpackage

// File: rtl/i2c_line_sampler.sv
// Synchronises SCL and SDA into the system clock and derives edge, start and
// stop pulses from the sampled values. Assumes the bus is much slower than clk.
// Both lines pass through identical stages, so they stay aligned.
module i2c_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_level,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic scl_prev, sda_prev, scl_now;

    // Synchroniser chains plus one history flop per line; idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
            scl_prev <= scl_sync[SYNC_STAGES-1];
            sda_prev <= sda_sync[SYNC_STAGES-1];
        end
    end

    // Event decode on the sampled lines.
    always_comb begin
        scl_now   = scl_sync[SYNC_STAGES-1];
        sda_level = sda_sync[SYNC_STAGES-1];
        scl_rise  = scl_now & ~scl_prev;
        scl_fall  = ~scl_now & scl_prev;
        start_det = scl_now & scl_prev & sda_prev & ~sda_level;
        stop_det  = scl_now & scl_prev & ~sda_prev & sda_level;
    end
endmodule

// File: rtl/eeprom_store.sv
// Register-held byte store with a one-page write buffer. Bytes are staged in
// the buffer with per-slot valid bits and copied into the store in a single
// clock on commit. Assumes commit and buffer writes never coincide.
module eeprom_store #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     buf_wr,
    input  logic [PAGE_W-1:0]        buf_slot,
    input  logic [7:0]               buf_data,
    input  logic                     buf_clear,
    input  logic                     commit,
    input  logic [ADDR_W-PAGE_W-1:0] page_base,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [7:0]               rd_data,
    output logic                     buf_pending
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PAGE  = 1 << PAGE_W;

    logic [7:0]      mem  [DEPTH];
    logic [7:0]      pbuf [PAGE];
    logic [PAGE-1:0] pvalid;

    // Slot valid flags: set on a buffered byte, cleared on discard or commit.
    always_ff @(posedge clk) begin
        if (!rst_n)                  pvalid <= '0;
        else if (buf_clear || commit) pvalid <= '0;
        else if (buf_wr)             pvalid[buf_slot] <= 1'b1;
    end

    // Page buffer data, needs no reset because the valid flags guard it.
    always_ff @(posedge clk) begin
        if (buf_wr) pbuf[buf_slot] <= buf_data;
    end

    // Store array: cleared by reset, loaded from valid buffer slots on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (commit) begin
            for (int j = 0; j < PAGE; j++)
                if (pvalid[j]) mem[{page_base, PAGE_W'(j)}] <= pbuf[j];
        end
    end

    // Read port and buffer status.
    always_comb begin
        rd_data     = mem[rd_addr];
        buf_pending = |pvalid;
    end
endmodule

// File: rtl/eeprom_i2c_ctrl.sv
// Two-wire slave protocol engine: device byte match, word pointer, data
// acknowledge, read shifting, and the busy timer that follows a commit.
// Assumes event pulses from i2c_line_sampler. SDA changes only after a
// sampled SCL fall, start or stop.
module eeprom_i2c_ctrl
    import eeprom_i2c_pkg::*;
#(
    parameter int         ADDR_W       = 8,
    parameter int         PAGE_W       = 3,
    parameter int         WRITE_CYCLES = 1000,
    parameter logic [3:0] DEV_TYPE     = 4'b1010
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scl_rise,
    input  logic                     scl_fall,
    input  logic                     sda_level,
    input  logic                     start_det,
    input  logic                     stop_det,
    input  logic [2:0]               strap_i,
    input  logic [7:0]               rd_data,
    input  logic                     buf_pending,
    output logic                     sda_oe_o,
    output logic                     buf_wr,
    output logic [PAGE_W-1:0]        buf_slot,
    output logic [7:0]               buf_data,
    output logic                     buf_clear,
    output logic                     commit,
    output logic [ADDR_W-PAGE_W-1:0] page_base,
    output logic [ADDR_W-1:0]        rd_addr,
    output logic                     busy_o
);
    localparam int BUSY_W = $clog2(WRITE_CYCLES + 1);

    bus_state_t        state;
    rx_phase_t         phase;
    logic [3:0]        cnt;
    logic [7:0]        shreg;
    logic [ADDR_W-1:0] ptr;
    logic              rw;
    logic [BUSY_W-1:0] busy_cnt;
    logic              ev_start, ev_stop, dev_match, byte_in_done;

    // Gate bus events while the write window runs and decode byte matches.
    always_comb begin
        busy_o       = (busy_cnt != '0);
        ev_start     = start_det & ~busy_o;
        ev_stop      = stop_det & ~busy_o;
        dev_match    = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == strap_i);
        byte_in_done = (state == ST_RX) && scl_fall && (cnt == 4'd8);
        buf_wr       = byte_in_done && (phase == PH_DATA) && ~busy_o
                       && ~start_det && ~stop_det;
        buf_slot     = ptr[PAGE_W-1:0];
        buf_data     = shreg;
        buf_clear    = ev_start;
        commit       = ev_stop & buf_pending;
        page_base    = ptr[ADDR_W-1:PAGE_W];
        rd_addr      = ptr;
    end

    // Write window timer: loaded on commit, counts down to idle.
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_cnt <= '0;
        else if (commit) busy_cnt <= BUSY_W'(WRITE_CYCLES);
        else if (busy_o) busy_cnt <= busy_cnt - BUSY_W'(1);
    end

    // Bus engine: byte reception, acknowledge, transmit and master acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            phase    <= PH_DEV;
            cnt      <= '0;
            shreg    <= '0;
            ptr      <= '0;
            rw       <= 1'b0;
            sda_oe_o <= 1'b0;
        end else if (busy_o) begin
            state    <= ST_IDLE;
            sda_oe_o <= 1'b0;
        end else if (ev_start) begin
            state    <= ST_RX;
            phase    <= PH_DEV;
            cnt      <= '0;
            sda_oe_o <= 1'b0;
        end else if (ev_stop) begin
            state    <= ST_IDLE;
            sda_oe_o <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (scl_rise && cnt != 4'd8) begin
                        shreg <= {shreg[6:0], sda_level};
                        cnt   <= cnt + 4'd1;
                    end else if (byte_in_done) begin
                        cnt <= '0;
                        case (phase)
                            PH_DEV: begin
                                if (dev_match) begin
                                    rw       <= shreg[0];
                                    sda_oe_o <= 1'b1;
                                    state    <= ST_ACK;
                                end else begin
                                    state    <= ST_IDLE;
                                end
                            end
                            PH_ADDR: begin
                                ptr      <= shreg[ADDR_W-1:0];
                                sda_oe_o <= 1'b1;
                                state    <= ST_ACK;
                            end
                            default: begin
                                ptr      <= {ptr[ADDR_W-1:PAGE_W],
                                             ptr[PAGE_W-1:0] + PAGE_W'(1)};
                                sda_oe_o <= 1'b1;
                                state    <= ST_ACK;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (phase == PH_DEV && rw) begin
                            shreg    <= rd_data;
                            sda_oe_o <= ~rd_data[7];
                            state    <= ST_TX;
                        end else begin
                            sda_oe_o <= 1'b0;
                            phase    <= (phase == PH_DEV) ? PH_ADDR : PH_DATA;
                            state    <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (cnt == 4'd7) begin
                            cnt      <= '0;
                            sda_oe_o <= 1'b0;
                            ptr      <= ptr + ADDR_W'(1);
                            state    <= ST_RACK;
                        end else begin
                            cnt      <= cnt + 4'd1;
                            shreg    <= {shreg[6:0], 1'b0};
                            sda_oe_o <= ~shreg[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        if (sda_level) state <= ST_IDLE;
                        else           cnt   <= 4'd1;
                    end else if (scl_fall && cnt == 4'd1) begin
                        cnt      <= '0;
                        shreg    <= rd_data;
                        sda_oe_o <= ~rd_data[7];
                        state    <= ST_TX;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/eeprom_i2c_slave.sv
// Top of the two-wire byte store: line sampler, protocol engine and store.
// Assumes an external pull-up on SDA; sda_oe_o = 1 pulls the line low.
module eeprom_i2c_slave #(
    parameter int         ADDR_W       = 8,
    parameter int         PAGE_BYTES   = 8,
    parameter int         WRITE_CYCLES = 1000,
    parameter logic [3:0] DEV_TYPE     = 4'b1010,
    parameter int         SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    output logic       sda_oe_o
);
    localparam int PAGE_W = $clog2(PAGE_BYTES);

    logic                     scl_rise, scl_fall, sda_level, start_det, stop_det;
    logic                     buf_wr, buf_clear, commit, buf_pending, wr_busy;
    logic [PAGE_W-1:0]        buf_slot;
    logic [7:0]               buf_data, rd_data;
    logic [ADDR_W-PAGE_W-1:0] page_base;
    logic [ADDR_W-1:0]        rd_addr;

    i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) sampler_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_level(sda_level),
        .start_det(start_det), .stop_det(stop_det)
    );

    eeprom_i2c_ctrl #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W),
        .WRITE_CYCLES(WRITE_CYCLES), .DEV_TYPE(DEV_TYPE)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_level(sda_level),
        .start_det(start_det), .stop_det(stop_det), .strap_i(strap_i),
        .rd_data(rd_data), .buf_pending(buf_pending), .sda_oe_o(sda_oe_o),
        .buf_wr(buf_wr), .buf_slot(buf_slot), .buf_data(buf_data),
        .buf_clear(buf_clear), .commit(commit), .page_base(page_base),
        .rd_addr(rd_addr), .busy_o(wr_busy)
    );

    eeprom_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) store_i (
        .clk(clk), .rst_n(rst_n), .buf_wr(buf_wr), .buf_slot(buf_slot),
        .buf_data(buf_data), .buf_clear(buf_clear), .commit(commit),
        .page_base(page_base), .rd_addr(rd_addr), .rd_data(rd_data),
        .buf_pending(buf_pending)
    );
endmodule

// File: rtl/eeprom_i2c_checker.sv
// Protocol properties of the byte store, attached to the top by bind.
// Assumes the signal names of eeprom_i2c_slave.
module eeprom_i2c_checker #(
    parameter int WRITE_CYCLES = 1000
) (
    input logic clk,
    input logic rst_n,
    input logic sda_oe,
    input logic scl_fall,
    input logic start_det,
    input logic stop_det,
    input logic busy,
    input logic buf_pending
);
    logic [31:0] busy_len;

    // Length of the current busy run, used to check the window size.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_len <= '0;
        else if (busy) busy_len <= busy_len + 32'd1;
        else           busy_len <= '0;
    end

    a_r11_sda_moves_on_events: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));

    a_r6_busy_keeps_released: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);

    a_r5_window_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_det));

    a_r5_window_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(buf_pending));

    a_r6_window_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == 32'(WRITE_CYCLES)));
endmodule

bind eeprom_i2c_slave eeprom_i2c_checker #(.WRITE_CYCLES(WRITE_CYCLES)) chk_i (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .busy(wr_busy),
    .buf_pending(buf_pending)
);

// File: tb/eeprom_i2c_slave_tb.sv
// Bench: drives the bus as a master and keeps its own model of the store.
module eeprom_i2c_slave_tb_top;
    localparam int         Q     = 6;
    localparam int         WCYC  = 500;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    wire  sda_bus = m_sda & ~sda_oe;
    logic [7:0] model [256];
    int n_tests = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    eeprom_i2c_slave #(.WRITE_CYCLES(WCYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .strap_i(STRAP), .sda_oe_o(sda_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        m_sda = b; tick(Q); m_scl = 1'b1; tick(Q);
        s = sda_bus; tick(Q); m_scl = 1'b0; tick(Q);
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic read_byte(output logic [7:0] d, input logic nack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            d[i] = s;
        end
        clk_bit(nack, s);
    endtask

    function automatic logic [7:0] dev(input logic [2:0] a, input logic rw);
        return {4'b1010, a, rw};
    endfunction

    // Page write of n bytes from addr; the model is updated only when stop is sent.
    task automatic write_seq(input logic [7:0] addr, input int n, input logic [7:0] salt,
                             input logic do_stop);
        logic ack;
        bus_start();
        write_byte(dev(STRAP, 1'b0), ack); chk("R1 write device ack", ack, 1);
        write_byte(addr, ack);             chk("R3 word pointer ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            logic [7:0] d = salt + 8'(k * 37);
            logic [2:0] slot = addr[2:0] + 3'(k);
            write_byte(d, ack);            chk("R3 R4 data ack", ack, 1);
            if (do_stop) model[{addr[7:3], slot}] = d;
        end
        if (do_stop) bus_stop();
    endtask

    task automatic poll(output int polls);
        logic ack;
        polls = 0;
        for (int p = 1; p <= 10; p++) begin
            bus_start();
            write_byte(dev(STRAP, 1'b0), ack);
            bus_stop();
            polls = p;
            if (ack) break;
        end
    endtask

    task automatic random_read(input logic [7:0] addr, input int n, input string tag);
        logic ack;
        logic [7:0] d;
        bus_start();
        write_byte(dev(STRAP, 1'b0), ack); chk({tag, " dummy write ack"}, ack, 1);
        write_byte(addr, ack);             chk({tag, " pointer ack"}, ack, 1);
        bus_start();
        write_byte(dev(STRAP, 1'b1), ack); chk({tag, " read device ack"}, ack, 1);
        for (int k = 0; k < n; k++) begin
            read_byte(d, k == n - 1);
            chk(tag, d, model[8'(addr + 8'(k))]);
        end
        bus_stop();
    endtask

    initial begin
        logic ack, ack2, s;
        logic [7:0] d;
        int polls;
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        tick(5);
        chk("R10 SDA released in reset", sda_oe, 0);
        rst_n = 1'b1;
        tick(5);
        chk("R10 SDA released after reset", sda_oe, 0);

        // R1 R2: every strap value; a mismatch must not acknowledge later bytes
        for (int a = 0; a < 8; a++) begin
            bus_start();
            write_byte(dev(3'(a), 1'b0), ack);
            chk("R1 strap match ack", ack, (3'(a) == STRAP) ? 1 : 0);
            if (!ack) begin
                write_byte(8'h00, ack2);
                chk("R2 ignored after mismatch", ack2, 0);
            end
            bus_stop();
        end
        // R1: every other type code is refused
        for (int t = 0; t < 16; t++) begin
            if (t == 10) continue;
            bus_start();
            write_byte({4'(t), STRAP, 1'b0}, ack);
            chk("R1 type code mismatch", ack, 0);
            bus_stop();
        end

        // R10 R8: current-address read from reset covers the whole store
        bus_start();
        write_byte(dev(STRAP, 1'b1), ack); chk("R8 read device ack", ack, 1);
        for (int i = 0; i < 256; i++) begin
            read_byte(d, i == 255);
            chk("R10 store cleared by reset", d, 0);
        end
        chk("R8 SDA released after nack", sda_oe, 0);
        bus_stop();

        // R3 R6: page write, then acknowledge polling
        write_seq(8'h00, 8, 8'h11, 1'b1);
        poll(polls);
        chk("R6 first poll refused", polls > 1, 1);
        chk("R6 poll accepted after window", polls <= 4, 1);
        random_read(8'h00, 8, "R7 random read page 0");

        // R4: ten bytes from 0xFC wrap inside the last page
        write_seq(8'hFC, 10, 8'h5A, 1'b1);
        poll(polls);
        chk("R6 second window polled", polls > 1 && polls <= 4, 1);
        random_read(8'hF8, 8, "R4 page wrap contents");
        random_read(8'hFE, 4, "R8 pointer wrap 255 to 0");

        // R5: repeated start discards data and opens no window
        write_seq(8'h40, 3, 8'hC3, 1'b0);
        bus_start();
        write_byte(dev(STRAP, 1'b0), ack);
        chk("R5 no busy window without stop", ack, 1);
        bus_stop();
        random_read(8'h40, 3, "R5 discarded data not stored");

        // R8: current-address read continues after a random read of 0x02
        random_read(8'h02, 1, "R7 single random read");
        bus_start();
        write_byte(dev(STRAP, 1'b1), ack); chk("R8 current read ack", ack, 1);
        read_byte(d, 1'b0); chk("R8 current address byte", d, model[3]);
        read_byte(d, 1'b1); chk("R8 sequential next byte", d, model[4]);
        bus_stop();

        // R9: abort a read after three bits, recover with nine clocks and a start
        bus_start();
        write_byte(dev(STRAP, 1'b1), ack); chk("R9 read before abort", ack, 1);
        for (int i = 0; i < 3; i++) clk_bit(1'b1, s);
        for (int i = 0; i < 9; i++) clk_bit(1'b1, s);
        chk("R9 SDA high after recovery clocks", s, 1);
        bus_start();
        write_byte(dev(STRAP, 1'b0), ack); chk("R9 address after recovery", ack, 1);
        bus_stop();
        random_read(8'h00, 2, "R9 reads after recovery");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule